// File: doc/BRIEF.md
# Byte-Wide Erasable PROM Model

This block is a synthesizable, cycle-based behavioural model of a byte-wide ultraviolet-erasable PROM, meant to stand in for the real memory inside the testbenches of device programmers and host buses. Its control pins are a low-active chip enable, a low-active output enable, a flag that says the programming voltage sits on the output-enable pin, a flag that says the supply is raised to its programming level, and a flag for the high voltage on address bit 9 that selects the identifier. From these pins it decodes six modes: read, standby, output-disable, program, program-verify and program-inhibit.

The data bus is split into a data-in path and a data-out path with its own drive enable, so a bench can model the tri-state pins. A separate `dataValid` output marks the cycles in which the driven byte is settled. Cells start erased to all ones, and programming can only clear bits. A single erase input restores the whole array. The array depth is a parameter, so the model can be a reduced-depth copy of the full 64K part. Access delay, output-enable delay and bus-float delay are all counted in clock cycles.

Top module: `byte_prom_model`

## Requirements
- R1: After reset, and at the clock edge that samples `eraseAll` high, every stored byte becomes 0xFF.
- R2: A program cycle stores old AND new, so a bit set to 1 on `dataIn` never turns a stored 0 back into 1.
- R3: Read mode is `chipEnN`=0, `outEnN`=0 and `progVolt`=0. In read mode `dataOutEn` is high and, once the delays of R9 and R10 have passed, `dataValid` is high and `dataOut` carries the stored byte at `addr`. With `vccProg`=1 this same mode serves as program-verify.
- R4: With `chipEnN`=1 (standby), `dataValid` is low from the next edge on, whatever level `outEnN` has, and `dataOutEn` falls as R11 describes. After reset, `dataOutEn`, `dataValid` and `progError` are all low.
- R5: With `chipEnN`=0 and `outEnN`=1 (output-disable), `dataValid` is low and the bus floats as R11 describes.
- R6: With `progVolt`=1 and `vccProg`=1, a low pulse on `chipEnN` that lasts from 1 to PULSE_MAX sampled edges writes `dataIn` into `addr`. The write takes place at the edge that samples `chipEnN` high again. The bus is not driven while programming.
- R7: With `progVolt`=1 and `chipEnN` held high (program-inhibit), nothing is written and the bus floats. A pulse given with `vccProg`=0 also writes nothing.
- R8: In read mode with `sigVolt`=1, `dataOut` returns 0x8F when `addr[0]`=0 and 0x85 when `addr[0]`=1, in place of the array contents.
- R9: After an address change, or a fall of `chipEnN`, is sampled at an edge, counted as edge 1, `dataValid` stays low up to edge ACC_CYC-1 and is high from edge ACC_CYC on.
- R10: After a fall of `outEnN` is sampled at edge 1, with the address long stable, `dataValid` stays low up to edge OE_CYC-1 and is high from edge OE_CYC on.
- R11: When read mode ends at a sampled edge (counted as edge 1), `dataOutEn` stays high through edge FLOAT_CYC and is low from edge FLOAT_CYC+1 on.
- R12: A program pulse that holds `chipEnN` low for more than PULSE_MAX sampled edges sets `progError` and writes nothing. `progError` clears at the next fall of `chipEnN` while `progVolt` and `vccProg` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rstN | input | 1 | Asynchronous reset, active low; erases the array |
| chipEnN | input | 1 | Chip enable, active low; also the program pulse |
| outEnN | input | 1 | Output enable, active low |
| progVolt | input | 1 | Programming voltage is present on the output-enable pin |
| vccProg | input | 1 | Supply is at its programming level |
| sigVolt | input | 1 | High voltage on address bit 9; selects the identifier |
| eraseAll | input | 1 | Erases the whole array to ones |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Byte to program |
| dataOut | output | 8 | Byte on the output pins |
| dataOutEn | output | 1 | High while the model drives the bus |
| dataValid | output | 1 | High while `dataOut` holds settled data |
| progError | output | 1 | Set when a program pulse is held low too long |

## Verification
On every cycle the assertions check the following: the quiet modes (standby, output-disable, programming voltage present) never present valid data; `dataValid` never appears without bus drive; a write never raises a stored bit; and a write never occurs while `progError` is set. Only the bench scenarios can show the exact edge counts for access, output-enable and float delays, the identifier bytes, the fact that inhibited and over-long pulses leave the array unchanged, and that erase restores all ones.

// File: rtl/prom_pkg.sv
package prom_pkg;
  // Strobes from the control to the datapath for one clock edge.
  typedef struct packed {
    logic wrEn;     // AND dataIn into the byte at addr
    logic loadOut;  // capture the read byte into the output register
    logic eraseAll; // set every stored bit to one
  } promStrobes_t;
endpackage

// File: rtl/prom_ctrl.sv
module prom_ctrl
  import prom_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ACC_CYC   = 4,
  parameter int OE_CYC    = 2,
  parameter int FLOAT_CYC = 2,
  parameter int PULSE_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progVolt,
  input  logic              vccProg,
  input  logic              eraseIn,
  input  logic [ADDR_W-1:0] addr,
  output promStrobes_t      stb,
  output logic              dataValid,
  output logic              dataOutEn,
  output logic              progError
);
  localparam int ACC_W = $clog2(ACC_CYC + 2);
  localparam int OE_W  = $clog2(OE_CYC + 2);
  localparam int FL_W  = $clog2(FLOAT_CYC + 2);
  localparam int PL_W  = $clog2(PULSE_MAX + 2);
  localparam logic [ACC_W-1:0] ACC_LIM  = ACC_W'(ACC_CYC);
  localparam logic [OE_W-1:0]  OE_LIM   = OE_W'(OE_CYC);
  localparam logic [FL_W-1:0]  FL_LIM   = FL_W'(FLOAT_CYC);
  localparam logic [PL_W-1:0]  PL_LIM   = PL_W'(PULSE_MAX);

  logic              ceQ, oeQ;
  logic [ADDR_W-1:0] addrQ;
  logic [ACC_W-1:0]  accCnt, accNext;
  logic [OE_W-1:0]   oeCnt, oeNext;
  logic [FL_W-1:0]   holdCnt, holdNext;
  logic [PL_W-1:0]   pulseCnt, pulseNext;
  logic              readReq, progArm, validNext, errNext, ceFall;

  assign readReq = !chipEnN && !outEnN && !progVolt;
  assign progArm = progVolt && vccProg;
  assign ceFall  = !chipEnN && ceQ;

  always_comb begin
    // cycles since the address or chip enable last changed
    if (chipEnN)                   accNext = '0;
    else if (ceQ || addr != addrQ) accNext = ACC_W'(1);
    else if (accCnt < ACC_LIM)     accNext = accCnt + 1'b1;
    else                           accNext = accCnt;
    // cycles since output enable fell
    if (outEnN)                    oeNext = '0;
    else if (oeQ)                  oeNext = OE_W'(1);
    else if (oeCnt < OE_LIM)       oeNext = oeCnt + 1'b1;
    else                           oeNext = oeCnt;
    validNext = readReq && (accNext >= ACC_LIM) && (oeNext >= OE_LIM);
    // bus hold time after read mode ends
    if (readReq)                   holdNext = FL_LIM;
    else if (holdCnt != '0)        holdNext = holdCnt - 1'b1;
    else                           holdNext = '0;
    // length of the current program pulse, saturating one past the limit
    if (!(progArm && !chipEnN))    pulseNext = '0;
    else if (pulseCnt > PL_LIM)    pulseNext = pulseCnt;
    else                           pulseNext = pulseCnt + 1'b1;
    if (pulseNext > PL_LIM)        errNext = 1'b1;
    else if (progArm && ceFall)    errNext = 1'b0;
    else                           errNext = progError;
  end

  always_comb begin
    stb.wrEn     = progArm && chipEnN && !ceQ &&
                   (pulseCnt != '0) && (pulseCnt <= PL_LIM);
    stb.loadOut  = validNext;
    stb.eraseAll = eraseIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ       <= 1'b1;
      oeQ       <= 1'b1;
      addrQ     <= '0;
      accCnt    <= '0;
      oeCnt     <= '0;
      holdCnt   <= '0;
      pulseCnt  <= '0;
      dataValid <= 1'b0;
      dataOutEn <= 1'b0;
      progError <= 1'b0;
    end else begin
      ceQ       <= chipEnN;
      oeQ       <= outEnN;
      addrQ     <= addr;
      accCnt    <= accNext;
      oeCnt     <= oeNext;
      holdCnt   <= holdNext;
      pulseCnt  <= pulseNext;
      dataValid <= validNext;
      dataOutEn <= readReq || (holdCnt != '0);
      progError <= errNext;
    end
  end

  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    chipEnN |=> !dataValid);
  assert_outdis_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && outEnN) |=> !dataValid);
  assert_inhibit_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    progVolt |=> !dataValid);
  assert_valid_on_bus_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> dataOutEn);
  assert_no_write_in_error_R12: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> !progError);
endmodule

// File: rtl/prom_array.sv
module prom_array
  import prom_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] MAKER_ID  = 8'h8F,
  parameter logic [7:0] DEVICE_ID = 8'h85
) (
  input  logic              clk,
  input  logic              rstN,
  input  promStrobes_t      stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sigVolt,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] readByte;

  // identifier bytes are chosen by the lowest address bit
  assign readByte = sigVolt ? (addr[0] ? DEVICE_ID : MAKER_ID) : mem[addr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (stb.eraseAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (stb.wrEn) begin
      mem[addr] <= mem[addr] & dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataOut <= 8'hFF;
    else if (stb.loadOut) dataOut <= readByte;
  end

  assert_clear_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && !stb.eraseAll) |=>
      ((mem[$past(addr)] & ~$past(mem[addr])) == 8'h00));
endmodule

// File: rtl/byte_prom_model.sv
module byte_prom_model
  import prom_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ACC_CYC   = 4,
  parameter int OE_CYC    = 2,
  parameter int FLOAT_CYC = 2,
  parameter int PULSE_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progVolt,
  input  logic              vccProg,
  input  logic              sigVolt,
  input  logic              eraseAll,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOutEn,
  output logic              dataValid,
  output logic              progError
);
  promStrobes_t stb;

  prom_ctrl #(
    .ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC),
    .FLOAT_CYC(FLOAT_CYC), .PULSE_MAX(PULSE_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .progVolt(progVolt), .vccProg(vccProg), .eraseIn(eraseAll),
    .addr(addr), .stb(stb), .dataValid(dataValid),
    .dataOutEn(dataOutEn), .progError(progError)
  );

  prom_array #(
    .ADDR_W(ADDR_W), .MAKER_ID(8'h8F), .DEVICE_ID(8'h85)
  ) u_array (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .sigVolt(sigVolt),
    .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: tb/byte_prom_model_tb.sv
module byte_prom_model_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int ACC = 4;
  localparam int OEC = 2;
  localparam int FLT = 2;
  localparam int PMAX = 4;

  logic clk = 1'b0;
  logic rstN, chipEnN, outEnN, progVolt, vccProg, sigVolt, eraseAll;
  logic [AW-1:0] addr;
  logic [7:0] dataIn, dataOut;
  logic dataOutEn, dataValid, progError;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit sampleReq = 1'b0;
  bit lastErr;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_prom_model #(
    .ADDR_W(AW), .ACC_CYC(ACC), .OE_CYC(OEC), .FLOAT_CYC(FLT), .PULSE_MAX(PMAX)
  ) u_dut (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .progVolt(progVolt), .vccProg(vccProg), .sigVolt(sigVolt),
    .eraseAll(eraseAll), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn), .dataValid(dataValid), .progError(progError)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops expected bytes and compares them a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (sampleReq && expQ.size() > 0) begin
      automatic logic [7:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      chk({t, " dataOut"}, {24'h0, dataOut}, {24'h0, e});
      chk({t, " dataOutEn"}, {31'h0, dataOutEn}, 32'h1);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_bus();
    chipEnN = 1'b1; outEnN = 1'b1; sigVolt = 1'b0;
    idle(FLT + 2);
  endtask

  // driver: opens a read, waits for settle, queues the expected byte
  task automatic readByte(input logic [AW-1:0] a, input logic sig,
                          input logic [7:0] exp, input string tag);
    @(negedge clk);
    progVolt = 1'b0; addr = a; sigVolt = sig; chipEnN = 1'b0; outEnN = 1'b0;
    idle(ACC + 1);
    chk({tag, " dataValid"}, {31'h0, dataValid}, 32'h1);
    expQ.push_back(exp); tagQ.push_back(tag);
    sampleReq = 1'b1;
    @(negedge clk);
    sampleReq = 1'b0;
    release_bus();
  endtask

  task automatic progByte(input logic [AW-1:0] a, input logic [7:0] d,
                          input int lowEdges, input logic vcc);
    @(negedge clk);
    progVolt = 1'b1; vccProg = vcc; chipEnN = 1'b1; outEnN = 1'b1;
    addr = a; dataIn = d;
    @(negedge clk);
    chipEnN = 1'b0;
    idle(lowEdges);
    lastErr = progError;
    chk("R6 bus released while programming", {31'h0, dataOutEn}, 32'h0);
    chipEnN = 1'b1;
    idle(1);
    progVolt = 1'b0; vccProg = 1'b0;
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; chipEnN = 1'b1; outEnN = 1'b1; progVolt = 1'b0; vccProg = 1'b0;
    sigVolt = 1'b0; eraseAll = 1'b0; addr = '0; dataIn = '0;
    idle(3);
    chk("R4 reset dataOutEn", {31'h0, dataOutEn}, 32'h0);
    chk("R4 reset dataValid", {31'h0, dataValid}, 32'h0);
    chk("R4 reset progError", {31'h0, progError}, 32'h0);
    rstN = 1'b1;
    idle(2);

    readByte(8'd5, 1'b0, 8'hFF, "R1 erased after reset");
    readByte(8'd255, 1'b0, 8'hFF, "R1 last address erased");

    progByte(8'd5, 8'hA5, 1, 1'b1);
    readByte(8'd5, 1'b0, 8'hA5, "R6 single edge pulse");
    progByte(8'd5, 8'h0F, PMAX, 1'b1);
    readByte(8'd5, 1'b0, 8'h05, "R2 and with old");
    progByte(8'd5, 8'hFF, 2, 1'b1);
    readByte(8'd5, 1'b0, 8'h05, "R2 ones do not set bits");
    progByte(8'd255, 8'h5A, 3, 1'b1);
    readByte(8'd255, 1'b0, 8'h5A, "R6 last address programmed");

    // R7: inhibit, CE held high with programming voltage present
    @(negedge clk);
    progVolt = 1'b1; vccProg = 1'b1; chipEnN = 1'b1; addr = 8'd5; dataIn = 8'h00;
    idle(3); dataIn = 8'h11; idle(3);
    chk("R7 inhibit bus floats", {31'h0, dataOutEn}, 32'h0);
    progVolt = 1'b0; vccProg = 1'b0;
    readByte(8'd5, 1'b0, 8'h05, "R7 inhibit leaves byte");
    progByte(8'd5, 8'h00, 2, 1'b0);
    readByte(8'd5, 1'b0, 8'h05, "R7 normal supply blocks write");

    // R12: over-long pulse
    progByte(8'd5, 8'h00, PMAX + 1, 1'b1);
    chk("R12 error raised", {31'h0, lastErr}, 32'h1);
    chk("R12 error held after pulse", {31'h0, progError}, 32'h1);
    readByte(8'd5, 1'b0, 8'h05, "R12 long pulse ignored");
    progByte(8'd6, 8'h3C, 2, 1'b1);
    chk("R12 error cleared by new pulse", {31'h0, progError}, 32'h0);
    readByte(8'd6, 1'b0, 8'h3C, "R12 following pulse writes");

    // R8: identifier
    readByte(8'd0, 1'b1, 8'h8F, "R8 maker byte");
    readByte(8'd1, 1'b1, 8'h85, "R8 device byte");
    readByte(8'd6, 1'b1, 8'h8F, "R8 even address maker");

    // R3: program-verify with raised supply
    @(negedge clk); vccProg = 1'b1;
    readByte(8'd6, 1'b0, 8'h3C, "R3 verify read");
    vccProg = 1'b0;

    // R5: output disable
    @(negedge clk); chipEnN = 1'b0; outEnN = 1'b1; addr = 8'd6;
    idle(ACC + FLT + 2);
    chk("R5 output-disable bus", {31'h0, dataOutEn}, 32'h0);
    chk("R5 output-disable valid", {31'h0, dataValid}, 32'h0);
    // R10: output enable falls, address long stable
    outEnN = 1'b0;
    idle(OEC - 1);
    chk("R10 not valid before delay", {31'h0, dataValid}, 32'h0);
    idle(1);
    chk("R10 valid at delay", {31'h0, dataValid}, 32'h1);
    // R9: address change while reading
    addr = 8'd5;
    idle(ACC - 1);
    chk("R9 not valid before delay", {31'h0, dataValid}, 32'h0);
    chk("R9 bus still driven", {31'h0, dataOutEn}, 32'h1);
    idle(1);
    chk("R9 valid at delay", {31'h0, dataValid}, 32'h1);
    chk("R9 new byte", {24'h0, dataOut}, 32'h05);
    // R11 / R4: chip enable rises, output enable stays low
    chipEnN = 1'b1;
    idle(1);
    chk("R4 standby drops valid", {31'h0, dataValid}, 32'h0);
    idle(FLT - 1);
    chk("R11 bus held through float delay", {31'h0, dataOutEn}, 32'h1);
    idle(1);
    chk("R11 bus floats after delay", {31'h0, dataOutEn}, 32'h0);
    idle(3);
    chk("R4 standby with output enable low", {31'h0, dataOutEn}, 32'h0);
    outEnN = 1'b1;

    // R9: chip-enable fall timing
    @(negedge clk); chipEnN = 1'b0; outEnN = 1'b0; addr = 8'd6;
    idle(ACC - 1);
    chk("R9 CE fall not valid early", {31'h0, dataValid}, 32'h0);
    idle(1);
    chk("R9 CE fall valid at delay", {31'h0, dataValid}, 32'h1);
    release_bus();

    // R1: erase input
    @(negedge clk); eraseAll = 1'b1;
    @(negedge clk); eraseAll = 1'b0;
    readByte(8'd6, 1'b0, 8'hFF, "R1 erase restores ones");
    readByte(8'd255, 1'b0, 8'hFF, "R1 erase last address");

    idle(4);
    finishRun();
  end
endmodule